// File: doc/BRIEF.md
# Counter CSR Access Permission Checker

This block decides whether a read of a user-level counter CSR may proceed. It covers the low halves of the cycle, time, retired-instruction and hardware performance counters 3 to 31. On a machine running in 32-bit mode it also covers their upper halves. The decision takes in the CSR address, the current privilege level, a virtualization flag, the machine's register width mode, whether supervisor mode and the counters extension exist, and three 32-bit counter-enable masks: machine, hypervisor and supervisor.

The masks are applied as layers with a fixed priority. The first denial decides the fault code. A denial by the machine mask always gives an illegal-instruction fault. A denial by the hypervisor mask gives a virtual-instruction fault. A denial by the supervisor mask gives a virtual-instruction fault under virtualization and an illegal-instruction fault otherwise. Addresses that are not counters raise a separate flag and never fault here. The result is registered, so the CSR stage reads it one clock after it presents the access.

Top module: `cnt_perm_check`

## Requirements
- R1: While reset is asserted, and after it until the first access, `fault` is 2'b00 and `not_counter` is 0.
- R2: The result for inputs present at a rising clock edge appears on the outputs after that edge. It is held until the next edge.
- R3: For a recognised counter address with `has_counters` low, `fault` is 2'b01 (illegal) at every privilege level.
- R4: Addresses 0xC00 to 0xC1F are counters in both width modes, with mask bit index equal to the address minus 0xC00 (0 cycle, 1 time, 2 instret, 3..31 performance counters).
- R5: Addresses 0xC80 to 0xC9F are counters only when `xlen32` is 1, with bit index equal to the address minus 0xC80. When `xlen32` is 0 they give `not_counter` = 1 and `fault` = 2'b00.
- R6: With privilege below machine (encodings user 2'b00, supervisor 2'b01, reserved 2'b10) and the indexed machine-mask bit clear, `fault` is 2'b01.
- R7: Otherwise, with `virt_on` high and the indexed hypervisor-mask bit clear, `fault` is 2'b10 (virtual-instruction).
- R8: Otherwise, with `has_smode` high, privilege user and the indexed supervisor-mask bit clear, `fault` is 2'b10 if `virt_on` is high and 2'b01 if not.
- R9: The checks are ordered extension, then machine mask, then hypervisor mask, then supervisor mask, and the first failing one decides. `fault` never takes the value 2'b11.
- R10: At machine privilege (2'b11) no mask can cause a fault.
- R11: Any address outside both counter ranges gives `not_counter` = 1 and `fault` = 2'b00, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address of the read |
| priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| virt_on | input | 1 | Virtualization mode active |
| xlen32 | input | 1 | Machine runs in 32-bit mode |
| has_smode | input | 1 | Supervisor mode implemented |
| has_counters | input | 1 | Counters extension implemented |
| men | input | 32 | Machine counter-enable mask |
| hen | input | 32 | Hypervisor counter-enable mask |
| sen | input | 32 | Supervisor counter-enable mask |
| fault | output | 2 | 00 none, 01 illegal instruction, 10 virtual-instruction fault |
| not_counter | output | 1 | Address is not a covered counter CSR |

## Verification
The bench builds the block with its default parameters: 32 counters, a 12-bit address, and range bases at 0xC00 and 0xC80. With these values every mask bit from 0 to 31 can be indexed, including the top bit at each range end. Addresses one below and one above each range are reachable. So is the upper range in both width modes. Random masks are often held at all ones, so that the hypervisor and supervisor layers behind the machine layer are exercised and not only the first layer.

// File: rtl/cnt_perm_pkg.sv
package cnt_perm_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_ILLEGAL = 2'b01,
        FLT_VIRT    = 2'b10
    } fault_e;

    localparam logic [1:0] PRIV_USER    = 2'b00;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    localparam int NUM_LAYERS = 3;
    localparam int LAY_MACH   = 0;
    localparam int LAY_HYP    = 1;
    localparam int LAY_SUP    = 2;

    typedef struct packed {
        fault_e fault;
        logic   not_counter;
    } chk_state_t;

endpackage

// File: rtl/cnt_addr_decode.sv
module cnt_addr_decode #(
    parameter int              ADDR_W  = 12,
    parameter int              CNT_NUM = 32,
    parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
    parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80,
    parameter int              IDX_W   = $clog2(CNT_NUM)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              xlen32,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] LO_END = LO_BASE + ADDR_W'(CNT_NUM - 1);
    localparam logic [ADDR_W-1:0] HI_END = HI_BASE + ADDR_W'(CNT_NUM - 1);

    logic lo_hit;
    logic hi_hit;

    always_comb begin
        lo_hit = (addr >= LO_BASE) && (addr <= LO_END);
        hi_hit = xlen32 && (addr >= HI_BASE) && (addr <= HI_END);
        hit    = lo_hit || hi_hit;
        if (lo_hit) begin
            idx = IDX_W'(addr - LO_BASE);
        end else begin
            idx = IDX_W'(addr - HI_BASE);
        end
    end
endmodule

// File: rtl/cnt_mask_select.sv
module cnt_mask_select #(
    parameter int CNT_NUM    = 32,
    parameter int NUM_LAYERS = 3,
    parameter int IDX_W      = $clog2(CNT_NUM)
) (
    input  logic [NUM_LAYERS-1:0][CNT_NUM-1:0] masks,
    input  logic [IDX_W-1:0]                   idx,
    output logic [NUM_LAYERS-1:0]              bit_set
);
    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        assign bit_set[g] = masks[g][idx];
    end
endmodule

// File: rtl/cnt_fault_resolve.sv
module cnt_fault_resolve
    import cnt_perm_pkg::*;
(
    input  logic                  has_counters,
    input  logic [1:0]            priv,
    input  logic                  virt_on,
    input  logic                  has_smode,
    input  logic [NUM_LAYERS-1:0] bit_set,
    output fault_e                fault
);
    logic below_mach;
    logic is_user;

    always_comb begin
        below_mach = (priv != PRIV_MACHINE);
        is_user    = (priv == PRIV_USER);
        fault      = FLT_NONE;
        if (!has_counters) begin
            fault = FLT_ILLEGAL;
        end else if (below_mach) begin
            if (!bit_set[LAY_MACH]) begin
                fault = FLT_ILLEGAL;
            end else if (virt_on && !bit_set[LAY_HYP]) begin
                fault = FLT_VIRT;
            end else if (has_smode && is_user && !bit_set[LAY_SUP]) begin
                fault = virt_on ? FLT_VIRT : FLT_ILLEGAL;
            end
        end
    end
endmodule

// File: rtl/cnt_perm_check.sv
module cnt_perm_check
    import cnt_perm_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter int                CNT_NUM = 32,
    parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
    parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [1:0]         priv,
    input  logic               virt_on,
    input  logic               xlen32,
    input  logic               has_smode,
    input  logic               has_counters,
    input  logic [CNT_NUM-1:0] men,
    input  logic [CNT_NUM-1:0] hen,
    input  logic [CNT_NUM-1:0] sen,
    output logic [1:0]         fault,
    output logic               not_counter
);
    localparam int IDX_W = $clog2(CNT_NUM);

    logic                              hit;
    logic [IDX_W-1:0]                  idx;
    logic [NUM_LAYERS-1:0][CNT_NUM-1:0] masks;
    logic [NUM_LAYERS-1:0]             bit_set;
    fault_e                            fault_w;
    chk_state_t                        state_d;
    chk_state_t                        state_q;

    always_comb begin
        masks           = '0;
        masks[LAY_MACH] = men;
        masks[LAY_HYP]  = hen;
        masks[LAY_SUP]  = sen;
    end

    cnt_addr_decode #(
        .ADDR_W (ADDR_W),
        .CNT_NUM(CNT_NUM),
        .LO_BASE(LO_BASE),
        .HI_BASE(HI_BASE),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr  (csr_addr),
        .xlen32(xlen32),
        .hit   (hit),
        .idx   (idx)
    );

    cnt_mask_select #(
        .CNT_NUM   (CNT_NUM),
        .NUM_LAYERS(NUM_LAYERS),
        .IDX_W     (IDX_W)
    ) u_select (
        .masks  (masks),
        .idx    (idx),
        .bit_set(bit_set)
    );

    cnt_fault_resolve u_resolve (
        .has_counters(has_counters),
        .priv        (priv),
        .virt_on     (virt_on),
        .has_smode   (has_smode),
        .bit_set     (bit_set),
        .fault       (fault_w)
    );

    always_comb begin
        state_d             = state_q;
        state_d.not_counter = !hit;
        state_d.fault       = hit ? fault_w : FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{fault: FLT_NONE, not_counter: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign fault       = state_q.fault;
    assign not_counter = state_q.not_counter;
endmodule

// File: rtl/cnt_perm_chk.sv
module cnt_perm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] csr_addr,
    input logic [1:0]  priv,
    input logic        virt_on,
    input logic        xlen32,
    input logic        has_counters,
    input logic [31:0] men,
    input logic [1:0]  fault,
    input logic        not_counter
);
    logic lo_rng;
    logic hi_rng;
    assign lo_rng = (csr_addr[11:5] == 7'h60);
    assign hi_rng = (csr_addr[11:5] == 7'h64);

    p_no_ext_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_counters && lo_rng) |=> (fault == 2'b01));

    p_mach_mask_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (has_counters && lo_rng && priv != 2'b11 && !men[csr_addr[4:0]])
        |=> (fault == 2'b01));

    p_machine_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (has_counters && lo_rng && priv == 2'b11) |=> (fault == 2'b00));

    p_upper_wide_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rng && !xlen32) |=> (not_counter && fault == 2'b00));

    p_other_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        not_counter |-> (fault == 2'b00));

    p_virt_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == 2'b10) |-> $past(virt_on));

    p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault != 2'b11));
endmodule

bind cnt_perm_check cnt_perm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .priv        (priv),
    .virt_on     (virt_on),
    .xlen32      (xlen32),
    .has_counters(has_counters),
    .men         (men),
    .fault       (fault),
    .not_counter (not_counter)
);

// File: tb/tb_cnt_perm_check.sv
module tb_cnt_perm_check;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] csr_addr;
    logic [1:0]  priv;
    logic        virt_on, xlen32, has_smode, has_counters;
    logic [31:0] men, hen, sen;
    logic [1:0]  fault;
    logic        not_counter;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    cnt_perm_check dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .priv(priv),
        .virt_on(virt_on), .xlen32(xlen32), .has_smode(has_smode),
        .has_counters(has_counters), .men(men), .hen(hen), .sen(sen),
        .fault(fault), .not_counter(not_counter)
    );

    // expected {not_counter, fault}
    function automatic logic [2:0] model(input logic [11:0] a, input logic [1:0] p,
        input logic v, input logic x32, input logic hs, input logic hc,
        input logic [31:0] m, input logic [31:0] h, input logic [31:0] s);
        int  i;
        bit  hitv;
        hitv = 0;
        i    = 0;
        if (a >= 12'hC00 && a <= 12'hC1F) begin hitv = 1; i = int'(a) - 'hC00; end
        else if (x32 && a >= 12'hC80 && a <= 12'hC9F) begin hitv = 1; i = int'(a) - 'hC80; end
        if (!hitv) return 3'b100;
        if (!hc) return 3'b001;
        if (p == 2'b11) return 3'b000;
        if (!m[i]) return 3'b001;
        if (v && !h[i]) return 3'b010;
        if (hs && p == 2'b00 && !s[i]) return v ? 3'b010 : 3'b001;
        return 3'b000;
    endfunction

    task automatic check(input logic [2:0] exp, input string tag);
        vectors++;
        if ({not_counter, fault} !== exp) begin
            fails++;
            $display("FAIL %s actual nc=%0b fault=%02b expected nc=%0b fault=%02b",
                     tag, not_counter, fault, exp[2], exp[1:0]);
        end
    endtask

    task automatic apply(input logic [11:0] a, input logic [1:0] p, input logic v,
        input logic x32, input logic hs, input logic hc, input logic [31:0] m,
        input logic [31:0] h, input logic [31:0] s, input string tag);
        @(negedge clk);
        csr_addr = a; priv = p; virt_on = v; xlen32 = x32;
        has_smode = hs; has_counters = hc; men = m; hen = h; sen = s;
        @(posedge clk);
        @(negedge clk);
        check(model(a, p, v, x32, hs, hc, m, h, s), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] ones;
        ones = 32'hFFFF_FFFF;
        rst_n = 1'b0; csr_addr = 12'hC00; priv = 2'b00; virt_on = 1'b1;
        xlen32 = 1'b1; has_smode = 1'b1; has_counters = 1'b0;
        men = '0; hen = '0; sen = '0;
        repeat (3) @(negedge clk);
        check(3'b000, "R1 reset state");
        rst_n = 1'b1;

        // R2: old result stays until the next edge
        apply(12'hC00, 2'b11, 0, 1, 1, 1, ones, ones, ones, "R2 baseline");
        @(negedge clk);
        csr_addr = 12'hC04; priv = 2'b01; men = ~(32'h1 << 4);
        #2 check(3'b000, "R2 held before edge");
        @(posedge clk); @(negedge clk);
        check(3'b001, "R2 new after edge");

        apply(12'hC00, 2'b11, 0, 1, 1, 0, ones, ones, ones, "R3 no ext machine");
        apply(12'hC9F, 2'b00, 1, 1, 1, 0, ones, ones, ones, "R3 no ext upper");
        apply(12'hC05, 2'b00, 0, 0, 0, 1, 32'h20, 0, 0, "R4 bit5 set");
        apply(12'hC05, 2'b00, 0, 0, 0, 1, ~32'h20, ones, ones, "R4 bit5 clear");
        apply(12'hC1F, 2'b01, 0, 0, 0, 1, 32'h7FFF_FFFF, ones, ones, "R4 bit31");
        apply(12'hC83, 2'b01, 0, 1, 1, 1, ~32'h8, ones, ones, "R5 upper rv32");
        apply(12'hC83, 2'b01, 0, 0, 1, 1, 0, 0, 0, "R5 upper rv64");
        apply(12'hC9F, 2'b00, 0, 1, 1, 1, 32'h8000_0000, 0, 32'h8000_0000, "R5 upper top");
        apply(12'hC02, 2'b10, 0, 1, 1, 1, ~32'h4, ones, ones, "R6 reserved priv");
        apply(12'hC01, 2'b01, 1, 1, 1, 1, ones, ~32'h2, ones, "R7 hyp deny");
        apply(12'hC07, 2'b00, 0, 1, 1, 1, ones, ones, ~32'h80, "R8 sup deny plain");
        apply(12'hC07, 2'b00, 1, 1, 1, 1, ones, ones, ~32'h80, "R8 sup deny virt");
        apply(12'hC07, 2'b00, 1, 1, 0, 1, ones, ones, 0, "R8 no smode");
        apply(12'hC07, 2'b01, 0, 1, 1, 1, ones, ones, 0, "R8 supervisor exempt");
        apply(12'hC03, 2'b00, 1, 1, 1, 1, 0, 0, 0, "R9 machine first");
        apply(12'hC03, 2'b00, 1, 1, 1, 1, ones, 0, 0, "R9 hyp before sup");
        apply(12'hC1F, 2'b11, 1, 1, 1, 1, 0, 0, 0, "R10 machine free");
        apply(12'hBFF, 2'b00, 1, 1, 1, 0, 0, 0, 0, "R11 below low");
        apply(12'hC20, 2'b00, 1, 1, 1, 1, 0, 0, 0, "R11 above low");
        apply(12'hC7F, 2'b00, 1, 1, 1, 1, 0, 0, 0, "R11 below high");
        apply(12'hCA0, 2'b00, 1, 1, 1, 1, 0, 0, 0, "R11 above high");

        void'($urandom(32'h5EED_0C00));
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [1:0]  p;
            logic [31:0] m, h, s;
            int          sel;
            sel = int'($urandom % 8);
            case (sel)
                0, 1, 2, 3: a = 12'hC00 + 12'($urandom % 32);
                4, 5:       a = 12'hC80 + 12'($urandom % 32);
                6:          a = 12'($urandom);
                default: begin
                    case ($urandom % 4)
                        0: a = 12'hBFF;
                        1: a = 12'hC20;
                        2: a = 12'hC7F;
                        default: a = 12'hCA0;
                    endcase
                end
            endcase
            p = 2'($urandom);
            m = ($urandom % 2 == 0) ? 32'hFFFF_FFFF : $urandom;
            h = ($urandom % 2 == 0) ? 32'hFFFF_FFFF : $urandom;
            s = ($urandom % 2 == 0) ? 32'hFFFF_FFFF : $urandom;
            apply(a, p, 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 8) != 0, m, h, s, "R9 random vector");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule